// File: doc/BRIEF.md
# Predicated Three-Stage Instruction Pipeline

This block is the front end and execute control of a small 32-bit load/store processor. Three stages run at once: a fetch stage that places a word address on the instruction memory port and receives the word combinationally in the same cycle; a decode stage that holds the fetched word; and an execute stage that evaluates the instruction against the live condition flags. In linear code one instruction completes every cycle.

Every instruction carries a 4-bit predicate in its top bits. When the predicate fails against the N, Z, C and V flags, the instruction drains through execute as a bubble, with no register write, flag update or jump. A taken jump (a branch, a branch that saves a return address, or a data operation whose destination is the program counter) discards the two younger instructions in flight and restarts fetch at the target. Execute reaches the register file and the flag register through a small side port, and the write port is visible at the block's outputs.

The encoding is deliberately reduced: a branch class and a four-operation immediate data class. Every other class code executes as a no-operation.

Top module: `cpipe_core`

## Requirements
- R1: Reset is synchronous. While it is held, and in the first cycle after release, the fetch address is 0 and both decode and execute are empty. The flags read 0. The word at address 0 reaches execute in the second cycle after release.
- R2: In linear code the fetch address grows by 4 every cycle. A word fetched at address A is in execute two cycles later, and successive execute cycles show successive addresses.
- R3: When a data operation names register 15 as its source, it reads its own address plus 8.
- R4: Bits [31:28] are the predicate: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), 1110 always, 1111 never.
- R5: An instruction whose predicate fails writes no register and changes no flag. It also redirects nothing: the next sequential address enters execute in the following cycle.
- R6: A branch has bits [27:25]=101, a link bit at [24] and a 24-bit offset at [23:0]. Its target is its address plus 8 plus the sign-extended offset times 4. The fetch address equals the target in the cycle after the branch executes. The two younger instructions are discarded, execute is empty for two cycles, and then it holds the target.
- R7: A branch with bit [24] set writes its own address plus 4 into register 14.
- R8: A data operation has bits [27:25]=001, an operation at [22:21], S at [20], source at [19:16], destination at [15:12] and a zero-extended 12-bit immediate at [11:0]. The operations are 00 (load the immediate), 01 (source plus immediate), 10 (source minus immediate) and 11 (the immediate shifted left by 20). The result goes out on the write port to the destination.
- R9: With S=1 the flags, output as {N,Z,C,V} on bits 3..0, take: N from result bit 31; Z set for a zero result; C from the carry out of an add, or set when a subtract has no borrow; V set on signed overflow. The two move operations keep C and V. With S=0 the flags are unchanged.
- R10: An executed data operation whose destination is register 15 jumps to the result with bits [1:0] cleared. It flushes in the same way as a branch and makes no write-port write.
- R11: Offset 0x800000 reaches back 32 MB and 0x7FFFFF reaches forward 32 MB minus 4. Target arithmetic wraps modulo 2^32.
- R12: Any class code in [27:25] other than 001 or 101 executes as a no-operation, with no write, no flag change and no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Fetch word address |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_addr | output | 32 | Address of the instruction in execute |
| ex_pass | output | 1 | Instruction in execute passed its predicate |
| wr_en | output | 1 | Register write this cycle |
| wr_idx | output | 4 | Register written |
| wr_data | output | 32 | Value written |
| flags | output | 4 | {N,Z,C,V} |

## Verification
On every cycle, the embedded properties check the stage ordering (decode holds the successor of execute, and decode moves into execute unless a flush intervenes). They also check that a redirect empties both stages and loads the fetch address, that a failed predicate or a clear S bit leaves the flags untouched, and that register 15 is never stored. Only the directed scenarios can show the values involved: the predicate truth table over several flag states, the address-plus-8 read, branch and link targets and return addresses, the extreme offsets, and which flushed instructions never wrote.

// File: rtl/cpipe_pkg.sv
package cpipe_pkg;
    localparam int XLEN   = 32;
    localparam int RIW    = 4;
    localparam int NREG   = 1 << RIW;
    localparam int PC_IDX = NREG - 1;
    localparam int LR_IDX = NREG - 2;
    localparam int OFFW   = 24;
    localparam int IMMW   = 12;
    localparam int HI_SH  = 20;

    localparam logic [2:0] CL_DP = 3'b001;
    localparam logic [2:0] CL_BR = 3'b101;

    typedef enum logic [1:0] {
        OP_MOV  = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_MOVH = 2'b11
    } dp_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            dv;
        logic [XLEN-1:0] di;
        logic [XLEN-1:0] da;
        logic            ev;
        logic [XLEN-1:0] ei;
        logic [XLEN-1:0] ea;
        flags_t          fl;
    } pipe_t;
endpackage

// File: rtl/cpipe_cond.sv
module cpipe_cond
    import cpipe_pkg::*;
(
    input  logic [3:0] cc,
    input  flags_t     fl,
    output logic       pass
);
    always_comb begin
        case (cc)
            4'h0:    pass = fl.z;
            4'h1:    pass = !fl.z;
            4'h2:    pass = fl.c;
            4'h3:    pass = !fl.c;
            4'h4:    pass = fl.n;
            4'h5:    pass = !fl.n;
            4'h6:    pass = fl.v;
            4'h7:    pass = !fl.v;
            4'h8:    pass = fl.c && !fl.z;
            4'h9:    pass = !fl.c || fl.z;
            4'hA:    pass = (fl.n == fl.v);
            4'hB:    pass = (fl.n != fl.v);
            4'hC:    pass = !fl.z && (fl.n == fl.v);
            4'hD:    pass = fl.z || (fl.n != fl.v);
            4'hE:    pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpipe_exec.sv
module cpipe_exec
    import cpipe_pkg::*;
(
    input  logic [27:0]     body,
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] rn_val,
    input  flags_t          f_in,
    output logic [RIW-1:0]  rn_idx,
    output logic            wr_req,
    output logic [RIW-1:0]  wr_idx,
    output logic [XLEN-1:0] wr_data,
    output logic            set_flags,
    output flags_t          f_out,
    output logic            jump_req,
    output logic [XLEN-1:0] jump_addr
);
    logic [XLEN-1:0] pc8, opa, immx, res;
    logic [XLEN:0]   wide;
    logic [RIW-1:0]  rd;
    logic            c_new, v_new;

    always_comb begin
        pc8    = addr + XLEN'(8);
        rn_idx = body[19:16];
        rd     = body[15:12];
        immx   = XLEN'(body[IMMW-1:0]);
        opa    = (rn_idx == RIW'(PC_IDX)) ? pc8 : rn_val;
        wide   = '0;
        res    = '0;
        c_new  = f_in.c;
        v_new  = f_in.v;
        unique case (dp_op_e'(body[22:21]))
            OP_MOV:  res = immx;
            OP_MOVH: res = immx << HI_SH;
            OP_ADD: begin
                wide  = {1'b0, opa} + {1'b0, immx};
                res   = wide[XLEN-1:0];
                c_new = wide[XLEN];
                v_new = (opa[XLEN-1] == immx[XLEN-1]) && (res[XLEN-1] != opa[XLEN-1]);
            end
            OP_SUB: begin
                wide  = {1'b0, opa} - {1'b0, immx};
                res   = wide[XLEN-1:0];
                c_new = !wide[XLEN];
                v_new = (opa[XLEN-1] != immx[XLEN-1]) && (res[XLEN-1] != opa[XLEN-1]);
            end
        endcase

        wr_req    = 1'b0;
        wr_idx    = rd;
        wr_data   = res;
        set_flags = 1'b0;
        f_out     = '{n: res[XLEN-1], z: (res == '0), c: c_new, v: v_new};
        jump_req  = 1'b0;
        jump_addr = '0;

        if (body[27:25] == CL_DP) begin
            set_flags = body[20];
            if (rd == RIW'(PC_IDX)) begin
                jump_req  = 1'b1;
                jump_addr = {res[XLEN-1:2], 2'b00};
            end else begin
                wr_req = 1'b1;
            end
        end else if (body[27:25] == CL_BR) begin
            jump_req  = 1'b1;
            jump_addr = pc8 + {{(XLEN-OFFW-2){body[OFFW-1]}}, body[OFFW-1:0], 2'b00};
            if (body[24]) begin
                wr_req  = 1'b1;
                wr_idx  = RIW'(LR_IDX);
                wr_data = addr + XLEN'(4);
            end
        end
    end
endmodule

// File: rtl/cpipe_rf.sv
module cpipe_rf
    import cpipe_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [RIW-1:0]  widx,
    input  logic [XLEN-1:0] wdata,
    input  logic [RIW-1:0]  ridx,
    output logic [XLEN-1:0] rdata
);
    logic [XLEN-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == PC_IDX) begin : g_pc
            assign regs_q[g] = '0;
        end else begin : g_gpr
            always_ff @(posedge clk) begin
                if (rst)
                    regs_q[g] <= '0;
                else if (we && widx == RIW'(g))
                    regs_q[g] <= wdata;
            end
        end
    end

    assign rdata = regs_q[ridx];

    // R10
    no_pc_store_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (widx != RIW'(PC_IDX)));
endmodule

// File: rtl/cpipe_core.sv
module cpipe_core
    import cpipe_pkg::*;
#(
    parameter logic [31:0] RESET_ADDR = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic        ex_valid,
    output logic [31:0] ex_addr,
    output logic        ex_pass,
    output logic        wr_en,
    output logic [3:0]  wr_idx,
    output logic [31:0] wr_data,
    output logic [3:0]  flags
);
    pipe_t s_q, s_d;

    logic            cond_ok, fire, redirect;
    logic [RIW-1:0]  rn_idx, x_idx;
    logic [XLEN-1:0] rn_val, x_data, jump_addr;
    logic            wr_req, set_flags, jump_req;
    flags_t          f_out;

    cpipe_cond u_cond (
        .cc   (s_q.ei[31:28]),
        .fl   (s_q.fl),
        .pass (cond_ok)
    );

    cpipe_exec u_exec (
        .body      (s_q.ei[27:0]),
        .addr      (s_q.ea),
        .rn_val    (rn_val),
        .f_in      (s_q.fl),
        .rn_idx    (rn_idx),
        .wr_req    (wr_req),
        .wr_idx    (x_idx),
        .wr_data   (x_data),
        .set_flags (set_flags),
        .f_out     (f_out),
        .jump_req  (jump_req),
        .jump_addr (jump_addr)
    );

    cpipe_rf u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .widx  (x_idx),
        .wdata (x_data),
        .ridx  (rn_idx),
        .rdata (rn_val)
    );

    assign fire = s_q.ev && cond_ok;

    always_comb begin
        s_d      = s_q;
        redirect = fire && jump_req;
        s_d.pc   = redirect ? jump_addr : s_q.pc + XLEN'(4);
        s_d.dv   = !redirect;
        s_d.di   = imem_data;
        s_d.da   = s_q.pc;
        s_d.ev   = s_q.dv && !redirect;
        s_d.ei   = s_q.di;
        s_d.ea   = s_q.da;
        if (fire && set_flags)
            s_d.fl = f_out;
        if (rst) begin
            s_d    = '0;
            s_d.pc = RESET_ADDR;
        end
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign imem_addr = s_q.pc;
    assign ex_valid  = s_q.ev;
    assign ex_addr   = s_q.ea;
    assign ex_pass   = fire;
    assign wr_en     = fire && wr_req;
    assign wr_idx    = x_idx;
    assign wr_data   = x_data;
    assign flags     = s_q.fl;

    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    always_ff @(posedge clk) begin
        if (!rst && rst_seen_q) begin
            // R1
            reset_state_chk: assert (s_q.pc == RESET_ADDR && !s_q.dv && !s_q.ev && s_q.fl == '0);
        end
    end

    // R2
    stage_order_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.dv && s_q.ev) |-> (s_q.da == s_q.ea + XLEN'(4)));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.dv && !redirect) |=> (s_q.ev && s_q.ea == $past(s_q.da)));

    // R6
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (!s_q.dv && !s_q.ev && s_q.pc == $past(jump_addr)));

    // R5
    bubble_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.ev && !cond_ok) |=> $stable(s_q.fl));

    // R9
    sbit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.ev && s_q.ei[27:25] == CL_DP && !s_q.ei[20]) |=> $stable(s_q.fl));
endmodule

// File: tb/cpipe_core_test.sv
`timescale 1ns/1ps
module cpipe_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, ex_addr, wr_data;
    logic        ex_valid, ex_pass, wr_en;
    logic [3:0]  wr_idx, flags;

    always #2 clk = ~clk;

    logic [31:0] mem [64];
    assign imem_data = mem[imem_addr[7:2]];

    cpipe_core uut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .ex_valid(ex_valid), .ex_addr(ex_addr), .ex_pass(ex_pass),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .flags(flags)
    );

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] AL = 4'hE, EQ = 4'h0, NE = 4'h1;
    localparam logic [31:0] NOP = 32'hE000_0000;

    logic        rec = 1'b0;
    int          tr_n, wl_n;
    logic        tr_v [64];
    logic        tr_p [64];
    logic [31:0] tr_a [64];
    logic [31:0] tr_f [64];
    logic [3:0]  wl_i [64];
    logic [31:0] wl_d [64];

    always @(negedge clk) begin
        if (rec) begin
            if (tr_n < 64) begin
                tr_v[tr_n] = ex_valid; tr_a[tr_n] = ex_addr;
                tr_f[tr_n] = imem_addr; tr_p[tr_n] = ex_pass;
                tr_n++;
            end
            if (wr_en && wl_n < 64) begin
                wl_i[wl_n] = wr_idx; wl_d[wl_n] = wr_data; wl_n++;
            end
        end
    end

    function automatic logic [31:0] dp(input logic [3:0] cc, input logic [1:0] op,
                                       input logic s, input logic [3:0] rn,
                                       input logic [3:0] rd, input logic [11:0] imm);
        return {cc, 3'b001, 2'b00, op, s, rn, rd, imm};
    endfunction

    function automatic logic [31:0] br(input logic [3:0] cc, input logic l, input logic [23:0] off);
        return {cc, 3'b101, l, off};
    endfunction

    function automatic bit cond_ref(input logic [3:0] cc, input logic [3:0] f);
        bit n = f[3], z = f[2], c = f[1], v = f[0];
        case (cc)
            4'h0: return z;        4'h1: return !z;
            4'h2: return c;        4'h3: return !c;
            4'h4: return n;        4'h5: return !n;
            4'h6: return v;        4'h7: return !v;
            4'h8: return c && !z;  4'h9: return !c || z;
            4'hA: return n == v;   4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = NOP;
    endtask

    task automatic run_prog(input int n);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        tr_n = 0; wl_n = 0; rst = 1'b0;
        @(posedge clk); rec = 1'b1;
        repeat (n) @(negedge clk);
        @(posedge clk); rec = 1'b0;
    endtask

    task automatic chk_reg(input logic [3:0] idx, input logic [31:0] exp, input string tag);
        logic found = 1'b0;
        logic [31:0] v = '0;
        for (int i = 0; i < wl_n; i++)
            if (wl_i[i] == idx) begin found = 1'b1; v = wl_d[i]; end
        chk(found && v == exp, tag, v, exp);
    endtask

    task automatic chk_nowr(input logic [3:0] idx, input string tag);
        int cnt = 0;
        for (int i = 0; i < wl_n; i++) if (wl_i[i] == idx) cnt++;
        chk(cnt == 0, tag, cnt, 0);
    endtask

    task automatic chk_tr(input int k, input logic v, input logic [31:0] a, input string tag);
        logic [31:0] act = tr_v[k] ? tr_a[k] : 32'hFFFF_FFFF;
        logic [31:0] exp = v ? a : 32'hFFFF_FFFF;
        chk(act == exp, tag, act, exp);
    endtask

    // Reset state, linear flow, PC read and plain data operations
    task automatic t_seq();
        clear_mem();
        mem[0] = dp(AL, 2'b00, 1'b0, 4'd0, 4'd1, 12'd100);
        mem[1] = dp(AL, 2'b01, 1'b0, 4'd1, 4'd2, 12'd23);
        mem[2] = dp(AL, 2'b01, 1'b0, 4'd15, 4'd4, 12'd0);
        mem[3] = dp(AL, 2'b10, 1'b0, 4'd15, 4'd5, 12'd4);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(imem_addr == 0, "R1 fetch address in reset", imem_addr, 0);
        chk(!ex_valid && !wr_en, "R1 execute empty in reset", {30'd0, ex_valid, wr_en}, 0);
        chk(flags == 0, "R1 flags in reset", flags, 0);
        run_prog(8);
        chk_tr(0, 1'b0, 0, "R1 execute empty first cycle");
        chk(tr_f[0] == 32'd4, "R2 fetch after first edge", tr_f[0], 4);
        chk(tr_f[1] == 32'd8, "R2 fetch advances by 4", tr_f[1], 8);
        chk_tr(1, 1'b1, 32'd0, "R1 first word in execute");
        chk_tr(2, 1'b1, 32'd4, "R2 consecutive execute");
        chk_tr(3, 1'b1, 32'd8, "R2 consecutive execute");
        chk_reg(4'd1, 32'd100, "R8 move immediate");
        chk_reg(4'd2, 32'd123, "R8 add uses previous result");
        chk_reg(4'd4, 32'd16, "R3 pc read is addr+8");
        chk_reg(4'd5, 32'd16, "R3 pc read minus 4");
        chk(flags == 4'b0000, "R9 no S bit keeps flags", flags, 0);
    endtask

    // Predicate table over one flag state
    task automatic t_cond(input logic [31:0] s0, input logic [31:0] s1, input logic [3:0] fexp);
        clear_mem();
        mem[0] = s0;
        mem[1] = s1;
        for (int i = 0; i < 16; i++)
            mem[2 + i] = dp(4'(i), 2'b00, 1'b0, 4'd0, 4'd1, 12'(i + 1));
        run_prog(24);
        chk(flags == fexp, "R9 flags after setup", flags, fexp);
        for (int i = 0; i < 16; i++) begin
            bit hit = 1'b0;
            bit exp = cond_ref(4'(i), fexp);
            for (int j = 0; j < wl_n; j++)
                if (wl_i[j] == 4'd1 && wl_d[j] == 32'(i + 1)) hit = 1'b1;
            chk(hit == exp, $sformatf("R4 predicate %0d flags %b", i, fexp), 32'(hit), 32'(exp));
        end
    endtask

    // Failed predicates and unknown classes are bubbles
    task automatic t_fail();
        clear_mem();
        mem[0] = dp(AL, 2'b00, 1'b1, 4'd0, 4'd0, 12'd0);
        mem[1] = dp(NE, 2'b10, 1'b1, 4'd0, 4'd2, 12'd1);
        mem[2] = dp(NE, 2'b00, 1'b0, 4'd0, 4'd3, 12'd9);
        mem[3] = br(NE, 1'b1, 24'd8);
        mem[4] = {AL, 3'b111, 1'b1, 4'hF, 4'd6, 16'hFFFF};
        mem[5] = dp(AL, 2'b00, 1'b0, 4'd0, 4'd4, 12'd1);
        run_prog(10);
        chk_nowr(4'd2, "R5 failed subtract no write");
        chk_nowr(4'd3, "R5 failed move no write");
        chk_nowr(4'd14, "R5 failed link no write");
        chk_nowr(4'd6, "R12 unknown class no write");
        chk(!tr_p[2] && !tr_p[3] && !tr_p[4], "R5 failed predicates reported", {tr_p[2], tr_p[3], tr_p[4]}, 0);
        chk_tr(5, 1'b1, 32'd16, "R5 no redirect after failed branch");
        chk_tr(6, 1'b1, 32'd20, "R12 no redirect after unknown class");
        chk_reg(4'd4, 32'd1, "R5 following instruction runs");
        chk(flags == 4'b0100, "R5 R12 flags untouched", flags, 4'b0100);
    endtask

    // Branch and branch with link, forward and backward
    task automatic t_branch();
        clear_mem();
        mem[0]  = br(AL, 1'b0, 24'd6);
        mem[1]  = dp(AL, 2'b00, 1'b0, 4'd0, 4'd1, 12'd1);
        mem[2]  = dp(AL, 2'b00, 1'b0, 4'd0, 4'd1, 12'd2);
        mem[8]  = br(AL, 1'b1, 24'hFFFFFA);
        mem[9]  = dp(AL, 2'b00, 1'b0, 4'd0, 4'd1, 12'd3);
        mem[10] = dp(AL, 2'b00, 1'b0, 4'd0, 4'd1, 12'd4);
        mem[4]  = dp(AL, 2'b00, 1'b0, 4'd0, 4'd2, 12'd7);
        run_prog(10);
        chk_tr(1, 1'b1, 32'h0, "R6 branch executes");
        chk(tr_f[2] == 32'h20, "R6 fetch at target", tr_f[2], 32'h20);
        chk_tr(2, 1'b0, 0, "R6 first bubble");
        chk_tr(3, 1'b0, 0, "R6 second bubble");
        chk_tr(4, 1'b1, 32'h20, "R6 target executes");
        chk(tr_f[5] == 32'h10, "R6 backward fetch", tr_f[5], 32'h10);
        chk_tr(7, 1'b1, 32'h10, "R6 backward target executes");
        chk_reg(4'd14, 32'h24, "R7 link holds addr+4");
        chk_nowr(4'd1, "R6 flushed words never write");
        chk_reg(4'd2, 32'd7, "R6 target instruction writes");
    endtask

    // Write to register 15
    task automatic t_pcwrite();
        clear_mem();
        mem[0]  = dp(AL, 2'b00, 1'b0, 4'd0, 4'd15, 12'h043);
        mem[1]  = dp(AL, 2'b00, 1'b0, 4'd0, 4'd1, 12'd1);
        mem[2]  = dp(AL, 2'b00, 1'b0, 4'd0, 4'd1, 12'd2);
        mem[16] = dp(AL, 2'b00, 1'b0, 4'd0, 4'd2, 12'd3);
        run_prog(8);
        chk(tr_f[2] == 32'h40, "R10 fetch at aligned result", tr_f[2], 32'h40);
        chk_tr(2, 1'b0, 0, "R10 bubble");
        chk_tr(3, 1'b0, 0, "R10 bubble");
        chk_tr(4, 1'b1, 32'h40, "R10 target executes");
        chk_nowr(4'd15, "R10 no write of register 15");
        chk_nowr(4'd1, "R10 flushed words never write");
        chk_reg(4'd2, 32'd3, "R10 target instruction writes");
    endtask

    // Largest offsets
    task automatic t_extreme();
        clear_mem();
        mem[0] = br(AL, 1'b0, 24'h800000);
        run_prog(4);
        chk(tr_f[2] == 32'hFE00_0008, "R11 backward 32 MB", tr_f[2], 32'hFE00_0008);
        clear_mem();
        mem[0] = br(AL, 1'b0, 24'h7FFFFF);
        run_prog(4);
        chk(tr_f[2] == 32'h0200_0004, "R11 forward limit", tr_f[2], 32'h0200_0004);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired R1 actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        t_seq();
        t_cond(dp(AL, 2'b00, 1'b1, 4'd0, 4'd0, 12'd0), NOP, 4'b0100);
        t_cond(dp(AL, 2'b10, 1'b1, 4'd0, 4'd0, 12'd1), NOP, 4'b1000);
        t_cond(dp(AL, 2'b00, 1'b0, 4'd0, 4'd0, 12'd5), dp(AL, 2'b10, 1'b1, 4'd0, 4'd0, 12'd3), 4'b0010);
        t_cond(dp(AL, 2'b11, 1'b0, 4'd0, 4'd0, 12'h800), dp(AL, 2'b10, 1'b1, 4'd0, 4'd0, 12'd1), 4'b0011);
        t_cond(dp(AL, 2'b11, 1'b0, 4'd0, 4'd0, 12'h800), dp(AL, 2'b10, 1'b1, 4'd0, 4'd0, 12'd0), 4'b1010);
        t_fail();
        t_branch();
        t_pcwrite();
        t_extreme();
        summary();
        $finish;
    end
endmodule